// File: doc/BRIEF.md
# Transmit Attempt Status Queue

This block keeps the outcome of transmit attempts for one Ethernet MAC port. Each attempt, whether it succeeded or failed, arrives from the transmit engine as a one-cycle event that carries its outcome flags. The block packs those flags into an 8-bit status word and stores the word in a small queue of two entries. An 8-bit CPU register port sees the queue as a single register. Each read returns the oldest stored word and removes it from the queue.

Two configuration inputs change how the queue fills. One drops the status of successful attempts, so only exceptions take up space. The other raises a hold signal toward the transmit engine while both entries are occupied, so no status is lost.

With the hold mode off, an attempt that finds both entries full is discarded, and a sticky overflow flag records the loss. An interrupt request stays high while at least one entry is stored and interrupts are enabled.

Top module: `tx_status_queue`

## Requirements
- R1: Reset clears every output to zero and empties the queue, so the first read after reset returns 0x00. The overflow flag is also cleared.
- R2: Each cycle with `evt_valid` high stores one status word, unless R6 or a full queue prevents it. The word's bits are: bit0 success, bit1 deferred, bit2 collision, bit3 sixteenth-attempt collision, bit4 late collision, bit5 FIFO underrun, bit6 carrier lost, bit7 SQE.
- R3: An event with `evt_coll16` high sets both bit3 and bit2 of the stored word, even when `evt_coll` is low.
- R4: A `rd_strobe` cycle puts the oldest stored word on `rd_data` after the next clock edge and removes that word. Words leave in arrival order. `rd_data` holds its value until the next strobe.
- R5: A read that finds the queue empty puts 0x00 on `rd_data`.
- R6: While `cfg_skip_ok` is high, an event with `evt_ok` high is not stored. Events without `evt_ok` are still stored.
- R7: While `cfg_halt_full` is high, `tx_hold` is high from the clock edge at which the queue becomes full until the edge at which a read frees an entry. An event that arrives while the queue is full in this mode is dropped and leaves `ovf` unchanged.
- R8: While `cfg_halt_full` is low, an event that finds the queue full without a read in the same cycle is dropped and sets `ovf`. `ovf` then stays high until reset.
- R9: `irq` is a registered output. It is high after a clock edge exactly when the queue holds at least one word and `cfg_irq_en` was high at that edge.
- R10: When a read and an event arrive in the same cycle and the queue is full, the read returns the oldest word and the new word is stored. No overflow is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_skip_ok | input | 1 | Do not store status of successful attempts |
| cfg_halt_full | input | 1 | Hold transmission while the queue is full |
| cfg_irq_en | input | 1 | Interrupt enable |
| evt_valid | input | 1 | One transmit attempt finished this cycle |
| evt_ok | input | 1 | Attempt succeeded |
| evt_deferred | input | 1 | Attempt was deferred |
| evt_coll | input | 1 | Attempt saw a collision |
| evt_coll16 | input | 1 | Collision on the sixteenth consecutive attempt |
| evt_late | input | 1 | Late collision |
| evt_underrun | input | 1 | Transmit FIFO ran empty |
| evt_crs_lost | input | 1 | Carrier sense error during transmission |
| evt_sqe | input | 1 | SQE test status |
| rd_strobe | input | 1 | CPU read of the status register |
| rd_data | output | 8 | Oldest status word, or 0x00 if the queue was empty |
| irq | output | 1 | Interrupt request |
| tx_hold | output | 1 | Hold off new transmissions |
| ovf | output | 1 | Sticky status-lost flag |

## Verification
Single-flag events and an all-high-nibble event show that each outcome lands on its own bit. A sixteenth-attempt event without the plain collision flag shows that the collision bit is forced. Interleaved writes and reads expose ordering and empty-read behaviour. Filling the queue under each hold setting separates a silent drop from a drop that sets `ovf`, and a read and event in the same cycle on a full queue tells a swap apart from a loss. Successful and deferred events under skip mode, together with toggling the interrupt enable, separate the storage path from the request path.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  localparam int STAT_W = 8;

  // Packed so that bit0 is the success flag; CPU software decodes these positions.
  typedef struct packed {
    logic sqe;
    logic crs_lost;
    logic underrun;
    logic late;
    logic coll16;
    logic coll;
    logic deferred;
    logic ok;
  } tx_stat_t;
endpackage

// File: rtl/tsq_encode.sv
module tsq_encode
  import tsq_pkg::*;
(
  input  logic              evt_valid,
  input  tx_stat_t          evt_flags,
  input  logic              cfg_skip_ok,
  output logic              push,
  output logic [STAT_W-1:0] word
);
  tx_stat_t st;

  always_comb begin
    st      = evt_flags;
    // A sixteenth consecutive collision is also a collision.
    st.coll = evt_flags.coll | evt_flags.coll16;
    word    = st;
    push    = evt_valid && !(cfg_skip_ok && evt_flags.ok);
  end
endmodule

// File: rtl/tsq_store.sv
module tsq_store #(
  parameter int DEPTH = 2,
  parameter int W     = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic                         pop,
  input  logic [W-1:0]                 wdata,
  output logic [W-1:0]                 rdata,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic [$clog2(DEPTH+1)-1:0]   count_nxt,
  output logic                         drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full, empty, pop_ok, push_ok;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    full      = (count == CW'(DEPTH));
    empty     = (count == '0);
    pop_ok    = pop && !empty;
    push_ok   = push && (!full || pop_ok);
    drop      = push && !push_ok;
    count_nxt = count + CW'(push_ok) - CW'(pop_ok);
  end

  // Storage without reset so it maps onto RAM.
  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= step(wp);
      if (pop_ok)  rp <= step(rp);
      count <= count_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      rdata <= '0;
    else if (pop) rdata <= empty ? '0 : mem[rp];
  end
endmodule

// File: rtl/tsq_flags.sv
module tsq_flags #(
  parameter int DEPTH = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [$clog2(DEPTH+1)-1:0] count_nxt,
  input  logic                       drop,
  input  logic                       cfg_irq_en,
  input  logic                       cfg_halt_full,
  output logic                       irq,
  output logic                       tx_hold,
  output logic                       ovf
);
  localparam int CW = $clog2(DEPTH+1);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= 1'b0;
      tx_hold <= 1'b0;
      ovf     <= 1'b0;
    end else begin
      irq     <= cfg_irq_en && (count_nxt != '0);
      tx_hold <= cfg_halt_full && (count_nxt == CW'(DEPTH));
      ovf     <= ovf | (drop && !cfg_halt_full);
    end
  end
endmodule

// File: rtl/tx_status_queue.sv
module tx_status_queue
  import tsq_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_skip_ok,
  input  logic              cfg_halt_full,
  input  logic              cfg_irq_en,
  input  logic              evt_valid,
  input  logic              evt_ok,
  input  logic              evt_deferred,
  input  logic              evt_coll,
  input  logic              evt_coll16,
  input  logic              evt_late,
  input  logic              evt_underrun,
  input  logic              evt_crs_lost,
  input  logic              evt_sqe,
  input  logic              rd_strobe,
  output logic [STAT_W-1:0] rd_data,
  output logic              irq,
  output logic              tx_hold,
  output logic              ovf
);
  localparam int CW = $clog2(DEPTH+1);

  tx_stat_t          flags;
  logic              push, drop;
  logic [STAT_W-1:0] word;
  logic [CW-1:0]     occ, occ_nxt;

  always_comb begin
    flags.ok       = evt_ok;
    flags.deferred = evt_deferred;
    flags.coll     = evt_coll;
    flags.coll16   = evt_coll16;
    flags.late     = evt_late;
    flags.underrun = evt_underrun;
    flags.crs_lost = evt_crs_lost;
    flags.sqe      = evt_sqe;
  end

  tsq_encode u_enc (
    .evt_valid   (evt_valid),
    .evt_flags   (flags),
    .cfg_skip_ok (cfg_skip_ok),
    .push        (push),
    .word        (word)
  );

  tsq_store #(.DEPTH(DEPTH), .W(STAT_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .pop       (rd_strobe),
    .wdata     (word),
    .rdata     (rd_data),
    .count     (occ),
    .count_nxt (occ_nxt),
    .drop      (drop)
  );

  tsq_flags #(.DEPTH(DEPTH)) u_flags (
    .clk           (clk),
    .rst           (rst),
    .count_nxt     (occ_nxt),
    .drop          (drop),
    .cfg_irq_en    (cfg_irq_en),
    .cfg_halt_full (cfg_halt_full),
    .irq           (irq),
    .tx_hold       (tx_hold),
    .ovf           (ovf)
  );
endmodule

// File: rtl/tsq_checker.sv
module tsq_checker #(
  parameter int DEPTH = 2
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       cfg_skip_ok,
  input logic                       cfg_halt_full,
  input logic                       cfg_irq_en,
  input logic                       evt_valid,
  input logic                       evt_ok,
  input logic                       rd_strobe,
  input logic [7:0]                 rd_data,
  input logic                       irq,
  input logic                       tx_hold,
  input logic                       ovf,
  input logic [$clog2(DEPTH+1)-1:0] occ
);
  localparam int CW = $clog2(DEPTH+1);

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst) occ <= CW'(DEPTH)); // R2
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && occ == '0) |=> rd_data == 8'h00); // R5
  AST_READ_POPS: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && occ != '0 && !evt_valid) |=> occ == $past(occ) - CW'(1)); // R4
  AST_SKIP_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_ok && cfg_skip_ok && !rd_strobe) |=> $stable(occ)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (occ == CW'(DEPTH) && evt_valid && !(evt_ok && cfg_skip_ok) && !rd_strobe && !cfg_halt_full)
    |=> ovf); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst) ovf |=> ovf); // R8
  AST_SWAP_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (occ == CW'(DEPTH) && rd_strobe && !ovf) |=> !ovf); // R10
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst) !cfg_irq_en |=> !irq); // R9
  AST_HOLD_MODE: assert property (@(posedge clk) disable iff (rst) !cfg_halt_full |=> !tx_hold); // R7
endmodule

bind tx_status_queue tsq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_skip_ok   (cfg_skip_ok),
  .cfg_halt_full (cfg_halt_full),
  .cfg_irq_en    (cfg_irq_en),
  .evt_valid     (evt_valid),
  .evt_ok        (evt_ok),
  .rd_strobe     (rd_strobe),
  .rd_data       (rd_data),
  .irq           (irq),
  .tx_hold       (tx_hold),
  .ovf           (ovf),
  .occ           (occ)
);

// File: tb/tx_status_queue_test.sv
module tx_status_queue_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst;
  logic cfg_skip_ok, cfg_halt_full, cfg_irq_en;
  logic evt_valid, evt_ok, evt_deferred, evt_coll, evt_coll16;
  logic evt_late, evt_underrun, evt_crs_lost, evt_sqe;
  logic rd_strobe;
  logic [7:0] rd_data;
  logic irq, tx_hold, ovf;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_status_queue uut (
    .clk(clk), .rst(rst),
    .cfg_skip_ok(cfg_skip_ok), .cfg_halt_full(cfg_halt_full), .cfg_irq_en(cfg_irq_en),
    .evt_valid(evt_valid), .evt_ok(evt_ok), .evt_deferred(evt_deferred),
    .evt_coll(evt_coll), .evt_coll16(evt_coll16), .evt_late(evt_late),
    .evt_underrun(evt_underrun), .evt_crs_lost(evt_crs_lost), .evt_sqe(evt_sqe),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .irq(irq), .tx_hold(tx_hold), .ovf(ovf)
  );

  // fl bit order matches the status word: ok, deferred, coll, coll16, late, underrun, crs, sqe
  typedef struct packed {
    logic       ev;
    logic [7:0] fl;
    logic       rd, sk, hd, ie;
    logic       cd;
    logic [7:0] xd;
    logic       xi, xh, xo;
    logic [7:0] rq;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'd2},  // R2 store success
    '{1'b1, 8'h04, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'd2},  // R2 store collision
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h01, 1'b1, 1'b0, 1'b0, 8'd4},  // R4 oldest first
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h04, 1'b0, 1'b0, 1'b0, 8'd4},  // R4 second
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'd5},  // R5 empty read
    '{1'b1, 8'h08, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'd3},  // R3 coll16 only
    '{1'b1, 8'hF0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'd2},  // R2 upper flags
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h0C, 1'b1, 1'b0, 1'b0, 8'd3},  // R3 both bits set
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'hF0, 1'b0, 1'b0, 1'b0, 8'd2},  // R2 upper word
    '{1'b1, 8'h03, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'd6},  // R6 success skipped
    '{1'b1, 8'h02, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'd6},  // R6 deferred kept
    '{1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h02, 1'b0, 1'b0, 1'b0, 8'd6},  // R6 only deferred word
    '{1'b1, 8'h01, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'd7},  // R7 one entry
    '{1'b1, 8'h02, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'd7},  // R7 full raises hold
    '{1'b1, 8'h04, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'd7},  // R7 drop, no ovf
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h01, 1'b1, 1'b0, 1'b0, 8'd7},  // R7 read drops hold
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h02, 1'b0, 1'b0, 1'b0, 8'd7},  // R7 dropped word absent
    '{1'b1, 8'h10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'd2},  // R2
    '{1'b1, 8'h20, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'd2},  // R2 full
    '{1'b1, 8'h40, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h10, 1'b1, 1'b0, 1'b0, 8'd10}, // R10 swap
    '{1'b1, 8'h80, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'd8},  // R8 overflow
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h20, 1'b1, 1'b0, 1'b1, 8'd8},  // R8 sticky
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h40, 1'b0, 1'b0, 1'b1, 8'd10}, // R10 new word kept
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 8'd8},  // R8 dropped word absent
    '{1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'd9},  // R9 masked
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'd9},  // R9 enabled
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h01, 1'b0, 1'b0, 1'b1, 8'd9}   // R9 drains
  };

  task automatic check(input string what, input int req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    evt_valid    = v.ev;
    evt_ok       = v.fl[0];
    evt_deferred = v.fl[1];
    evt_coll     = v.fl[2];
    evt_coll16   = v.fl[3];
    evt_late     = v.fl[4];
    evt_underrun = v.fl[5];
    evt_crs_lost = v.fl[6];
    evt_sqe      = v.fl[7];
    rd_strobe    = v.rd;
    cfg_skip_ok  = v.sk;
    cfg_halt_full = v.hd;
    cfg_irq_en   = v.ie;
  endtask

  task automatic idle();
    vec_t z;
    z = '0;
    drive(z);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    idle();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("rd_data after reset", 1, rd_data, 8'h00);
    check("irq after reset", 1, {7'b0, irq}, 8'h00);
    check("tx_hold after reset", 1, {7'b0, tx_hold}, 8'h00);
    check("ovf after reset", 1, {7'b0, ovf}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      if (VECS[i].cd) check($sformatf("vec %0d rd_data", i), int'(VECS[i].rq), rd_data, VECS[i].xd);
      check($sformatf("vec %0d irq", i), int'(VECS[i].rq), {7'b0, irq}, {7'b0, VECS[i].xi});
      check($sformatf("vec %0d tx_hold", i), int'(VECS[i].rq), {7'b0, tx_hold}, {7'b0, VECS[i].xh});
      check($sformatf("vec %0d ovf", i), int'(VECS[i].rq), {7'b0, ovf}, {7'b0, VECS[i].xo});
    end

    // R1: reset mid-run empties a loaded queue and clears the sticky flag
    idle();
    cfg_irq_en = 1'b1;
    evt_valid = 1'b1; evt_late = 1'b1;
    @(negedge clk);
    idle();
    cfg_irq_en = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("ovf cleared by reset R1", 1, {7'b0, ovf}, 8'h00);
    check("irq cleared by reset R1", 1, {7'b0, irq}, 8'h00);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    check("read after reset R1", 1, rd_data, 8'h00);

    // R4: rd_data holds between strobes
    evt_valid = 1'b1; evt_underrun = 1'b1;
    @(negedge clk);
    idle();
    cfg_irq_en = 1'b1;
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("rd_data held R4", 4, rd_data, 8'h20);

    finished = 1;
    summary();
    $finish;
  end
endmodule